// File: doc/BRIEF.md
# Overriding Two-Speed Branch Predictor

This block produces two predictions for every branch lookup. A fast answer comes back one cycle after the lookup. A slower, more accurate answer arrives three cycles after the lookup. The fast answer comes from a small direct-mapped tagged cache that mirrors entries of the slow pattern table. When that cache misses, a plain address-indexed counter table supplies the answer instead. The slow answer comes from a pipelined pattern table that accepts a new lookup on every cycle.

When the slow answer disagrees with the fast answer already given for the same lookup, the block raises `override` together with that lookup's tag, so that the fetch logic can start recovery. Resolved branches are written back through an update port. The update trains the pattern table and the fallback table, and it fills or refreshes the matching cache line. A flush input discards every lookup that is still in flight.

Top module: `override_bpred`

## Requirements
- R1: After reset, `fast_valid`, `slow_valid` and `override` are 0. Every cache line is invalid, and every counter holds 2'b01 (weakly not taken), so the first lookups miss and predict not taken.
- R2: A lookup is accepted when `lk_valid` is 1 and `flush` is 0. One cycle after an accepted lookup, `fast_valid` is 1 and `fast_seq` equals that lookup's `lk_seq`.
- R3: The combined index is PHT_IDX_W bits wide. Bit j is the XOR of every `lk_pc` bit i and every `lk_hist` bit i for which i mod PHT_IDX_W equals j. The cache set is the low SET_W bits of this index, and the tag is the remaining upper bits. A lookup hits when the set is valid and its stored tag matches. On a hit, `fast_hit` is 1 and `fast_pred` is bit 1 of the cached counter.
- R4: On a cache miss, `fast_hit` is 0 and `fast_pred` is bit 1 of the fallback counter. That counter is indexed by the PC folded in the same way into BIM_IDX_W bits.
- R5: Three cycles after an accepted lookup, `slow_valid` is 1, `slow_seq` equals the lookup's tag, and `slow_pred` is bit 1 of the pattern-table counter at the combined index.
- R6: Lookups may arrive on consecutive cycles. Each fast and slow result appears in lookup order, with its own tag.
- R7: `override` is 1 exactly when `slow_valid` is 1 and `slow_pred` differs from the fast prediction given for the same lookup. The tag of that lookup is on `slow_seq`. When the two predictions agree, `override` stays 0.
- R8: An update moves the pattern-table counter at the update's combined index, and the fallback counter at the update's folded PC, one step toward the outcome. Counters saturate at 0 and 3.
- R9: An update writes the cache set of its combined index: the line becomes valid, takes that index's tag, and takes the pattern counter's new value. A later lookup at that index hits, with the fast prediction equal to the slow one.
- R10: A cycle with `flush` at 1 discards every in-flight lookup and the lookup offered in that same cycle. After such a cycle, `fast_valid`, `slow_valid` and `override` are 0, and no discarded lookup ever produces a slow result or an override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Branch address |
| lk_hist | input | HIST_W | Global history |
| lk_seq | input | SEQ_W | Tag carried with the lookup |
| flush | input | 1 | Discard all in-flight lookups |
| upd_valid | input | 1 | Resolution update |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History used by the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| fast_valid | output | 1 | Fast result valid |
| fast_pred | output | 1 | Fast taken prediction |
| fast_hit | output | 1 | Fast result came from the cache |
| fast_seq | output | SEQ_W | Tag of the fast result |
| slow_valid | output | 1 | Slow result valid |
| slow_pred | output | 1 | Slow taken prediction |
| slow_seq | output | SEQ_W | Tag of the slow result and override |
| override | output | 1 | Slow result contradicts the fast one |

## Verification
An override needs the fallback table and the pattern table to disagree at the moment of a cache miss. From reset they agree everywhere. The bench therefore trains one address until its fallback counter says taken, then looks it up with a different history. That history lands on an untrained pattern entry and on a cache set that is still empty. The same setup is reused to show that a flush arriving one cycle later suppresses that override. The pipelined ordering is then shown by streaming back-to-back lookups after a training phase in which the sets have been filled with mixed tags.

// File: rtl/obp_pkg.sv
package obp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;

    localparam ctr_t CTR_INIT = CTR_WNT;

    function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
        ctr_t n;
        n = c;
        if (taken && c != CTR_ST)
            n = ctr_t'(c + 2'd1);
        else if (!taken && c != CTR_SNT)
            n = ctr_t'(c - 2'd1);
        return n;
    endfunction

    function automatic logic ctr_taken(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/obp_bimodal.sv
module obp_bimodal
    import obp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t ctr_q [ENTRIES];

    assign rd_taken = ctr_taken(ctr_q[rd_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
        end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr_next(ctr_q[upd_idx], upd_taken);
        end
    end

    AST_BIM_SAT_LO: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_taken && ctr_q[upd_idx] == CTR_SNT) |=> ctr_q[$past(upd_idx)] == CTR_SNT); // R8

endmodule

// File: rtl/obp_fast_cache.sv
module obp_fast_cache
    import obp_pkg::*;
#(
    parameter int SET_W = 3,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  ctr_t             wr_ctr
);
    localparam int SETS = 1 << SET_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        ctr_t             ctr;
    } line_t;

    line_t line_q [SETS];

    assign rd_hit   = line_q[rd_set].vld && (line_q[rd_set].tag == rd_tag);
    assign rd_taken = ctr_taken(line_q[rd_set].ctr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) line_q[i] <= '{vld: 1'b0, tag: '0, ctr: CTR_INIT};
        end else if (wr_en) begin
            line_q[wr_set] <= '{vld: 1'b1, tag: wr_tag, ctr: wr_ctr};
        end
    end

    AST_FILL_HITS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (line_q[$past(wr_set)].vld && line_q[$past(wr_set)].tag == $past(wr_tag)
                   && line_q[$past(wr_set)].ctr == $past(wr_ctr))); // R9

endmodule

// File: rtl/obp_slow_pht.sv
module obp_slow_pht
    import obp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int SEQ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_vld,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic             in_fpred,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken,
    output ctr_t             fill_ctr,
    output logic             out_valid,
    output logic             out_pred,
    output logic [SEQ_W-1:0] out_seq,
    output logic             out_fpred
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [SEQ_W-1:0] seq;
        logic             fpred;
    } addr_stage_t;

    typedef struct packed {
        logic             vld;
        logic             pred;
        logic [SEQ_W-1:0] seq;
        logic             fpred;
    } res_stage_t;

    ctr_t        pht_q [ENTRIES];
    addr_stage_t s1_q;
    res_stage_t  s2_q, s3_q;

    assign fill_ctr = ctr_next(pht_q[upd_idx], upd_taken);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) pht_q[i] <= CTR_INIT;
        end else if (upd_en) begin
            pht_q[upd_idx] <= fill_ctr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= '{vld: in_vld, idx: in_idx, seq: in_seq, fpred: in_fpred};
            s2_q <= '{vld: s1_q.vld, pred: ctr_taken(pht_q[s1_q.idx]),
                      seq: s1_q.seq, fpred: s1_q.fpred};
            s3_q <= s2_q;
        end
    end

    assign out_valid = s3_q.vld;
    assign out_pred  = s3_q.pred;
    assign out_seq   = s3_q.seq;
    assign out_fpred = s3_q.fpred;

    AST_SLOW_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_vld, 3) && out_seq == $past(in_seq, 3))); // R5
    AST_PHT_SAT_HI: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_taken && pht_q[upd_idx] == CTR_ST) |=> pht_q[$past(upd_idx)] == CTR_ST); // R8
    AST_PHT_SAT_LO: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_taken && pht_q[upd_idx] == CTR_SNT) |=> pht_q[$past(upd_idx)] == CTR_SNT); // R8

endmodule

// File: rtl/override_bpred.sv
module override_bpred
    import obp_pkg::*;
#(
    parameter int PC_W      = 12,
    parameter int HIST_W    = 8,
    parameter int PHT_IDX_W = 6,
    parameter int SET_W     = 3,
    parameter int BIM_IDX_W = 4,
    parameter int SEQ_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [HIST_W-1:0] lk_hist,
    input  logic [SEQ_W-1:0]  lk_seq,
    input  logic              flush,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken,
    output logic              fast_valid,
    output logic              fast_pred,
    output logic              fast_hit,
    output logic [SEQ_W-1:0]  fast_seq,
    output logic              slow_valid,
    output logic              slow_pred,
    output logic [SEQ_W-1:0]  slow_seq,
    output logic              override
);
    localparam int TAG_W = PHT_IDX_W - SET_W;

    logic [PHT_IDX_W-1:0] lk_idx, upd_idx;
    logic [BIM_IDX_W-1:0] lk_bidx, upd_bidx;

    always_comb begin
        lk_idx   = '0;
        upd_idx  = '0;
        lk_bidx  = '0;
        upd_bidx = '0;
        for (int i = 0; i < PC_W; i++) begin
            lk_idx[i % PHT_IDX_W]   ^= lk_pc[i];
            upd_idx[i % PHT_IDX_W]  ^= upd_pc[i];
            lk_bidx[i % BIM_IDX_W]  ^= lk_pc[i];
            upd_bidx[i % BIM_IDX_W] ^= upd_pc[i];
        end
        for (int i = 0; i < HIST_W; i++) begin
            lk_idx[i % PHT_IDX_W]  ^= lk_hist[i];
            upd_idx[i % PHT_IDX_W] ^= upd_hist[i];
        end
    end

    logic accept;
    assign accept = lk_valid && !flush;

    logic cache_hit, cache_taken, bim_taken, fast_now;
    ctr_t fill_ctr;
    logic slow_fpred;

    obp_bimodal #(.IDX_W(BIM_IDX_W)) u_bim (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_bidx),
        .rd_taken  (bim_taken),
        .upd_en    (upd_valid),
        .upd_idx   (upd_bidx),
        .upd_taken (upd_taken)
    );

    obp_fast_cache #(.SET_W(SET_W), .TAG_W(TAG_W)) u_cache (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (lk_idx[SET_W-1:0]),
        .rd_tag   (lk_idx[PHT_IDX_W-1:SET_W]),
        .rd_hit   (cache_hit),
        .rd_taken (cache_taken),
        .wr_en    (upd_valid),
        .wr_set   (upd_idx[SET_W-1:0]),
        .wr_tag   (upd_idx[PHT_IDX_W-1:SET_W]),
        .wr_ctr   (fill_ctr)
    );

    assign fast_now = cache_hit ? cache_taken : bim_taken;

    obp_slow_pht #(.IDX_W(PHT_IDX_W), .SEQ_W(SEQ_W)) u_slow (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .in_vld    (accept),
        .in_idx    (lk_idx),
        .in_seq    (lk_seq),
        .in_fpred  (fast_now),
        .upd_en    (upd_valid),
        .upd_idx   (upd_idx),
        .upd_taken (upd_taken),
        .fill_ctr  (fill_ctr),
        .out_valid (slow_valid),
        .out_pred  (slow_pred),
        .out_seq   (slow_seq),
        .out_fpred (slow_fpred)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_valid <= 1'b0;
            fast_pred  <= 1'b0;
            fast_hit   <= 1'b0;
            fast_seq   <= '0;
        end else begin
            fast_valid <= accept;
            fast_pred  <= fast_now;
            fast_hit   <= cache_hit;
            fast_seq   <= lk_seq;
        end
    end

    assign override = slow_valid && (slow_pred != slow_fpred);

    AST_FAST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        accept |=> (fast_valid && fast_seq == $past(lk_seq))); // R2
    AST_FLUSH_KILLS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!slow_valid && !fast_valid && !override)); // R10

endmodule

// File: tb/tb_override_bpred.sv
module tb_override_bpred;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, flush, upd_valid, upd_taken;
    logic [11:0] lk_pc, upd_pc;
    logic [7:0]  lk_hist, upd_hist;
    logic [3:0]  lk_seq;
    logic        fast_valid, fast_pred, fast_hit, slow_valid, slow_pred, override;
    logic [3:0]  fast_seq, slow_seq;

    always #10 clk = ~clk;

    override_bpred dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hist(lk_hist),
        .lk_seq(lk_seq), .flush(flush), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_hist(upd_hist), .upd_taken(upd_taken), .fast_valid(fast_valid),
        .fast_pred(fast_pred), .fast_hit(fast_hit), .fast_seq(fast_seq),
        .slow_valid(slow_valid), .slow_pred(slow_pred), .slow_seq(slow_seq),
        .override(override)
    );

    int total = 0;
    int fails = 0;
    logic [3:0] seq_n = 4'd0;

    logic [1:0] m_pht [64];
    logic [1:0] m_bim [16];
    logic       m_cv  [8];
    logic [2:0] m_ct  [8];
    logic [1:0] m_cc  [8];

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] m_idx(input logic [11:0] pc, input logic [7:0] h);
        logic [5:0] r = '0;
        for (int i = 0; i < 12; i++) r[i % 6] ^= pc[i];
        for (int i = 0; i < 8; i++)  r[i % 6] ^= h[i];
        return r;
    endfunction

    function automatic logic [3:0] m_bidx(input logic [11:0] pc);
        logic [3:0] r = '0;
        for (int i = 0; i < 12; i++) r[i % 4] ^= pc[i];
        return r;
    endfunction

    function automatic logic [1:0] m_sat(input logic [1:0] c, input logic t);
        if (t)  return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic m_expect(input logic [11:0] pc, input logic [7:0] h,
                            output logic hit, output logic fp, output logic sp);
        logic [5:0] ix = m_idx(pc, h);
        hit = m_cv[ix[2:0]] && (m_ct[ix[2:0]] == ix[5:3]);
        fp  = hit ? m_cc[ix[2:0]][1] : m_bim[m_bidx(pc)][1];
        sp  = m_pht[ix][1];
    endtask

    task automatic do_update(input logic [11:0] pc, input logic [7:0] h, input logic t);
        logic [5:0] ix = m_idx(pc, h);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
        m_pht[ix] = m_sat(m_pht[ix], t);
        m_bim[m_bidx(pc)] = m_sat(m_bim[m_bidx(pc)], t);
        m_cv[ix[2:0]] = 1'b1; m_ct[ix[2:0]] = ix[5:3]; m_cc[ix[2:0]] = m_pht[ix];
    endtask

    // Single lookup: fast checked one edge later, slow three edges later.
    task automatic do_lookup(input logic [11:0] pc, input logic [7:0] h, output logic ovr);
        logic hit, fp, sp;
        logic [3:0] s = seq_n;
        m_expect(pc, h, hit, fp, sp);
        seq_n = seq_n + 4'd1;
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_hist = h; lk_seq = s;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R2 fast_valid", int'(fast_valid), 1);
        chk("R2 fast_seq", int'(fast_seq), int'(s));
        chk("R3 fast_hit", int'(fast_hit), int'(hit));
        chk(hit ? "R3 fast_pred on hit" : "R4 fast_pred on miss", int'(fast_pred), int'(fp));
        chk("R5 slow_valid early", int'(slow_valid), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R5 slow_valid", int'(slow_valid), 1);
        chk("R5 slow_seq", int'(slow_seq), int'(s));
        chk("R5 slow_pred", int'(slow_pred), int'(sp));
        chk("R7 override", int'(override), int'(fp != sp));
        ovr = override;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic o;
        lk_valid = 0; flush = 0; upd_valid = 0; upd_taken = 0;
        lk_pc = 0; lk_hist = 0; lk_seq = 0; upd_pc = 0; upd_hist = 0;
        for (int i = 0; i < 64; i++) m_pht[i] = 2'd1;
        for (int i = 0; i < 16; i++) m_bim[i] = 2'd1;
        for (int i = 0; i < 8; i++) begin m_cv[i] = 0; m_ct[i] = 0; m_cc[i] = 2'd1; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 fast_valid", int'(fast_valid), 0);
        chk("R1 slow_valid", int'(slow_valid), 0);
        chk("R1 override", int'(override), 0);
        do_lookup(12'h000, 8'h00, o);
        chk("R1 first lookup miss", int'(fast_hit), 0);
        chk("R1 first prediction", int'(fast_pred), 0);

        // R7: train the fallback toward taken, then miss onto an untrained entry
        do_update(12'h010, 8'h00, 1'b1);
        do_update(12'h010, 8'h00, 1'b1);
        do_lookup(12'h010, 8'h01, o);
        chk("R7 disagreement raises override", int'(o), 1);
        do_lookup(12'h010, 8'h00, o);
        chk("R9 filled line hits", int'(fast_hit), 1);
        chk("R7 agreement no override", int'(o), 0);

        // R10: flush one cycle after the overriding lookup
        @(negedge clk);
        lk_valid = 1; lk_pc = 12'h010; lk_hist = 8'h01; lk_seq = 4'hA;
        @(negedge clk);
        flush = 1; lk_seq = 4'hB;
        @(negedge clk);
        flush = 0; lk_valid = 0;
        chk("R10 lookup in flush cycle dropped", int'(fast_valid), 0);
        for (int k = 0; k < 4; k++) begin
            chk("R10 no slow result", int'(slow_valid), 0);
            chk("R10 no override", int'(override), 0);
            @(negedge clk);
        end

        // R8: saturation at both ends, seen through the filled line
        do_update(12'h010, 8'h00, 1'b1);
        do_update(12'h010, 8'h00, 1'b1);
        do_update(12'h010, 8'h00, 1'b0);
        do_lookup(12'h010, 8'h00, o);
        chk("R8 saturated high then one step", int'(slow_pred), 1);
        for (int k = 0; k < 3; k++) do_update(12'h010, 8'h00, 1'b0);
        do_lookup(12'h010, 8'h00, o);
        chk("R8 saturated low", int'(slow_pred), 0);
        do_update(12'h010, 8'h00, 1'b1);
        do_lookup(12'h010, 8'h00, o);
        chk("R8 one step up from zero", int'(slow_pred), 0);

        // Training pass, then revisit and sweep
        for (int k = 0; k < 48; k++)
            do_update(12'((k * 37 + 5) % 4096), 8'((k * 11) % 256), (k % 3) != 0);
        for (int k = 0; k < 48; k++)
            do_lookup(12'((k * 37 + 5) % 4096), 8'((k * 11) % 256), o);
        for (int p = 0; p < 64; p++) begin
            do_lookup(12'((p * 67) % 4096), 8'h00, o);
            do_lookup(12'((p * 67) % 4096), 8'h15, o);
            do_lookup(12'((p * 67) % 4096), 8'hA3, o);
        end

        // R6: back-to-back stream
        begin
            logic [11:0] spc [10];
            logic [7:0]  sh  [10];
            logic        eh  [10];
            logic        efp [10];
            logic        esp [10];
            logic [3:0]  es  [10];
            for (int j = 0; j < 10; j++) begin
                spc[j] = 12'((j * 291 + 7) % 4096);
                sh[j]  = 8'((j * 53) % 256);
                m_expect(spc[j], sh[j], eh[j], efp[j], esp[j]);
                es[j] = seq_n; seq_n = seq_n + 4'd1;
            end
            @(negedge clk);
            lk_valid = 1; lk_pc = spc[0]; lk_hist = sh[0]; lk_seq = es[0];
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (i < 10) begin
                    chk("R6 stream fast_seq", int'(fast_seq), int'(es[i]));
                    chk("R6 stream fast_pred", int'(fast_pred), int'(efp[i]));
                end
                if (i >= 2) begin
                    chk("R6 stream slow_valid", int'(slow_valid), 1);
                    chk("R6 stream slow_seq", int'(slow_seq), int'(es[i-2]));
                    chk("R6 stream slow_pred", int'(slow_pred), int'(esp[i-2]));
                    chk("R7 stream override", int'(override), int'(efp[i-2] != esp[i-2]));
                end
                if (i + 1 < 10) begin
                    lk_pc = spc[i+1]; lk_hist = sh[i+1]; lk_seq = es[i+1];
                end else begin
                    lk_valid = 0;
                end
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule